// File: doc/BRIEF.md
# Sequenced Add/Subtract Register Datapath

This block is a small arithmetic datapath built around one shared adder/subtractor. Two input registers hold operands taken from two external data buses. A third register keeps the running result. A control word is presented on each cycle. It picks the source of each ALU port and chooses add or subtract. Each operand multiplexer can route the result register back into its port, so nested expressions are evaluated one operation per cycle without extra storage.

A controller outside the block streams control words, one per cycle, with a valid strobe. It reloads the input registers between steps. For example, A-((B+C)-D) is formed in three accepted words:
- add the two input registers;
- subtract a newly loaded D from the fed-back result;
- subtract the fed-back result from a newly loaded A.

The word that closes a sequence carries a "last" mark. The block then raises a one-cycle completion pulse.

Top module: `seq_addsub_dp`

## Requirements
- R1: A synchronous active-high reset clears both input registers, the result register and the completion flag to zero. After reset, adding the two input registers yields zero.
- R2: At a clock edge where the load enable is 1, the input registers capture `in_a` and `in_b`. While the load enable is 0, they keep their values.
- R3: An accepted word with op bit 0 (add) writes x+y modulo 2^WIDTH into the result register at that clock edge.
- R4: An accepted word with op bit 1 (subtract) writes x-y modulo 2^WIDTH into the result register at that clock edge.
- R5: Operand selection works as follows:
  - x-port select 0 takes the first input register; select 1 takes the result register.
  - y-port select 0 takes the second input register; select 1 takes the result register.
- R6: While `cw_valid` is 0, the result register holds its value, whatever the select, op and last inputs are.
- R7: `done` is 1 for exactly the cycle after an edge at which an accepted word had `cw_last` = 1. At all other times it is 0.
- R8: The three-word stream described above leaves B+C, then (B+C)-D, then A-((B+C)-D) in the result register on successive cycles. `done` rises together with the final value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load enable for both input registers |
| in_a | input | WIDTH | Data for the first input register |
| in_b | input | WIDTH | Data for the second input register |
| cw_valid | input | 1 | Control word valid strobe |
| cw_sel_x | input | 1 | x-port source: 0 first input register, 1 result feedback |
| cw_sel_y | input | 1 | y-port source: 0 second input register, 1 result feedback |
| cw_sub | input | 1 | Operation: 0 add, 1 subtract |
| cw_last | input | 1 | Marks the final word of a sequence |
| result | output | WIDTH | Result register contents |
| done | output | 1 | One-cycle completion pulse |

## Verification
Every output comes from a register, so the effect of an accepted control word shows on `result` and `done` one edge after the word is driven. An input-register load made at the same edge can only affect a word issued in a later cycle. The bench drives each table row on a falling edge and samples both outputs on the next falling edge, which is one rising edge later. The expected values of later rows therefore carry the register contents left by earlier rows. Reset is checked the same way: one edge after it is raised, and again one edge after an add of the cleared input registers.

// File: rtl/seq_addsub_pkg.sv
package seq_addsub_pkg;

    typedef enum logic {
        SRC_REG = 1'b0,
        SRC_FB  = 1'b1
    } src_e;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

    typedef struct packed {
        logic valid;
        src_e src_x;
        src_e src_y;
        op_e  op;
        logic last;
    } ctrl_t;

    localparam int unsigned N_PORTS = 2;

    function automatic logic ends_sequence(input ctrl_t c);
        return c.valid && c.last;
    endfunction

endpackage

// File: rtl/sa_regs.sv
module sa_regs #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_en,
    input  logic [WIDTH-1:0] d_a,
    input  logic [WIDTH-1:0] d_b,
    output logic [WIDTH-1:0] q_a,
    output logic [WIDTH-1:0] q_b
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_a <= '0;
            q_b <= '0;
        end else if (ld_en) begin
            q_a <= d_a;
            q_b <= d_b;
        end
    end

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> (q_a == $past(d_a) && q_b == $past(d_b))); // R2

    AST_LOAD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ld_en |=> ($stable(q_a) && $stable(q_b))); // R2

    AST_REGS_CLEARED: assert property (@(posedge clk)
        rst |=> (q_a == '0 && q_b == '0)); // R1

endmodule

// File: rtl/sa_opmux.sv
module sa_opmux
    import seq_addsub_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  src_e             sel,
    input  logic [WIDTH-1:0] reg_val,
    input  logic [WIDTH-1:0] fb_val,
    output logic [WIDTH-1:0] opnd
);

    always_comb begin
        unique case (sel)
            SRC_FB:  opnd = fb_val;
            default: opnd = reg_val;
        endcase
    end

endmodule

// File: rtl/sa_alu.sv
module sa_alu
    import seq_addsub_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  op_e              op,
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    output logic [WIDTH-1:0] res
);

    logic [WIDTH-1:0] y_eff;
    logic [WIDTH:0]   sum_full;

    // Subtraction as x + ~y + 1, so a single carry chain serves both operations.
    always_comb begin
        y_eff    = (op == OP_SUB) ? ~y : y;
        sum_full = {1'b0, x} + {1'b0, y_eff} + {{WIDTH{1'b0}}, (op == OP_SUB)};
        res      = sum_full[WIDTH-1:0];
    end

endmodule

// File: rtl/seq_addsub_dp.sv
module seq_addsub_dp
    import seq_addsub_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_en,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic             cw_valid,
    input  logic             cw_sel_x,
    input  logic             cw_sel_y,
    input  logic             cw_sub,
    input  logic             cw_last,
    output logic [WIDTH-1:0] result,
    output logic             done
);

    ctrl_t            ctrl;
    logic [WIDTH-1:0] r_a;
    logic [WIDTH-1:0] r_b;
    logic [WIDTH-1:0] acc_q;
    logic [WIDTH-1:0] alu_res;
    logic             done_q;

    logic [WIDTH-1:0] reg_src [N_PORTS];
    logic [WIDTH-1:0] opnd    [N_PORTS];
    src_e             sel     [N_PORTS];

    always_comb begin
        ctrl.valid = cw_valid;
        ctrl.src_x = src_e'(cw_sel_x);
        ctrl.src_y = src_e'(cw_sel_y);
        ctrl.op    = op_e'(cw_sub);
        ctrl.last  = cw_last;
    end

    sa_regs #(.WIDTH(WIDTH)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .ld_en (ld_en),
        .d_a   (in_a),
        .d_b   (in_b),
        .q_a   (r_a),
        .q_b   (r_b)
    );

    assign reg_src[0] = r_a;
    assign reg_src[1] = r_b;
    assign sel[0]     = ctrl.src_x;
    assign sel[1]     = ctrl.src_y;

    for (genvar g = 0; g < N_PORTS; g++) begin : g_port
        sa_opmux #(.WIDTH(WIDTH)) u_mux (
            .sel     (sel[g]),
            .reg_val (reg_src[g]),
            .fb_val  (acc_q),
            .opnd    (opnd[g])
        );
    end

    sa_alu #(.WIDTH(WIDTH)) u_alu (
        .op  (ctrl.op),
        .x   (opnd[0]),
        .y   (opnd[1]),
        .res (alu_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            done_q <= 1'b0;
        end else begin
            if (ctrl.valid) begin
                acc_q <= alu_res;
            end
            done_q <= ends_sequence(ctrl);
        end
    end

    assign result = acc_q;
    assign done   = done_q;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (result == '0 && !done)); // R1

    AST_ADD_RESULT: assert property (@(posedge clk) disable iff (rst)
        (cw_valid && !cw_sub) |=> (result == WIDTH'($past(opnd[0]) + $past(opnd[1])))); // R3

    AST_SUB_RESULT: assert property (@(posedge clk) disable iff (rst)
        (cw_valid && cw_sub) |=> (result == WIDTH'($past(opnd[0]) - $past(opnd[1])))); // R4

    AST_FEEDBACK_X: assert property (@(posedge clk) disable iff (rst)
        (cw_valid && cw_sel_x && !cw_sel_y && !cw_sub) |=>
            (result == WIDTH'($past(result) + $past(r_b)))); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cw_valid |=> $stable(result)); // R6

    AST_DONE_RISE: assert property (@(posedge clk) disable iff (rst)
        (cw_valid && cw_last) |=> done); // R7

    AST_DONE_LOW: assert property (@(posedge clk) disable iff (rst)
        !(cw_valid && cw_last) |=> !done); // R7

endmodule

// File: tb/seq_addsub_dp_tb.sv
`timescale 1ns/1ps
module seq_addsub_dp_tb;

    localparam int unsigned W = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic         ld_en;
    logic [W-1:0] in_a;
    logic [W-1:0] in_b;
    logic         cw_valid;
    logic         cw_sel_x;
    logic         cw_sel_y;
    logic         cw_sub;
    logic         cw_last;
    logic [W-1:0] result;
    logic         done;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    seq_addsub_dp #(.WIDTH(W)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .ld_en    (ld_en),
        .in_a     (in_a),
        .in_b     (in_b),
        .cw_valid (cw_valid),
        .cw_sel_x (cw_sel_x),
        .cw_sel_y (cw_sel_y),
        .cw_sub   (cw_sub),
        .cw_last  (cw_last),
        .result   (result),
        .done     (done)
    );

    typedef struct packed {
        logic         ld;
        logic [15:0]  a;
        logic [15:0]  b;
        logic         v;
        logic         sx;
        logic         sy;
        logic         sub;
        logic         last;
        logic [15:0]  exp_res;
        logic         exp_done;
        logic [3:0]   req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 16'h0005, 16'h0003, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 4'd6}, // R6 idle, R2 load 5/3
        '{1'b0, 16'h0000, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0008, 1'b0, 4'd3}, // R3 5+3
        '{1'b0, 16'h1111, 16'h2222, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0002, 1'b0, 4'd2}, // R2 hold, R4 5-3
        '{1'b0, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0005, 1'b0, 4'd5}, // R5 x=result 2 + 3
        '{1'b0, 16'h0000, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0000, 1'b0, 4'd5}, // R5 5 - y=result 5
        '{1'b0, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0000, 1'b0, 4'd6}, // R6 ignored word, R7 no pulse
        '{1'b1, 16'hFFFF, 16'h0002, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 4'd2}, // R2 load
        '{1'b0, 16'h0000, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0001, 1'b0, 4'd3}, // R3 wrap FFFF+2
        '{1'b1, 16'h0001, 16'h0003, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0001, 1'b0, 4'd6}, // R6 hold
        '{1'b0, 16'h0000, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'hFFFE, 1'b0, 4'd4}, // R4 wrap 1-3
        '{1'b0, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 16'hFFFC, 1'b1, 4'd7}, // R7 done, both feedback
        '{1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'hFFFC, 1'b0, 4'd7}, // R7 single pulse
        '{1'b1, 16'h0030, 16'h0020, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'hFFFC, 1'b0, 4'd8}, // R8 load B,C
        '{1'b1, 16'h0030, 16'h0010, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0050, 1'b0, 4'd8}, // R8 B+C, load D
        '{1'b1, 16'h0064, 16'h0010, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0040, 1'b0, 4'd8}, // R8 -D, load A
        '{1'b0, 16'h0000, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0024, 1'b1, 4'd8}, // R8 A-(...)
        '{1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0024, 1'b0, 4'd7}, // R7 pulse ends
        '{1'b1, 16'hFFFF, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0024, 1'b0, 4'd8}, // R8 load B,C
        '{1'b1, 16'hFFFF, 16'h0002, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 4'd8}, // R8 wrap B+C
        '{1'b1, 16'h0000, 16'h0002, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16'hFFFE, 1'b0, 4'd8}, // R8 -D
        '{1'b0, 16'h0000, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0002, 1'b1, 4'd8}  // R8 final
    };

    task automatic check(input string what, input int req,
                         input logic [W-1:0] exp_res, input logic exp_done);
        checks++;
        if (result !== exp_res || done !== exp_done) begin
            errors++;
            $display("FAIL R%0d %s: result=%h done=%b expected result=%h done=%b",
                     req, what, result, done, exp_res, exp_done);
        end
    endtask

    task automatic drive(input logic ld, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic v, input logic sx, input logic sy,
                         input logic sub, input logic last);
        ld_en = ld; in_a = a; in_b = b;
        cw_valid = v; cw_sel_x = sx; cw_sel_y = sy; cw_sub = sub; cw_last = last;
    endtask

    initial begin
        rst = 1'b1;
        drive(1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        check("reset state", 1, 16'h0000, 1'b0); // R1
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].ld, TBL[i].a, TBL[i].b, TBL[i].v,
                  TBL[i].sx, TBL[i].sy, TBL[i].sub, TBL[i].last);
            @(negedge clk);
            check($sformatf("vector %0d", i), int'(TBL[i].req),
                  TBL[i].exp_res, TBL[i].exp_done);
        end

        // R1: reset mid-run overrides an accepted last word and clears everything
        rst = 1'b1;
        drive(1'b1, 16'h7777, 16'h1234, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        check("reset overrides word", 1, 16'h0000, 1'b0);
        rst = 1'b0;
        drive(1'b0, 16'h5555, 16'h5555, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check("input registers cleared by reset", 1, 16'h0000, 1'b0); // R1

        // R2: load and accepted word at the same edge: the word sees the old registers
        drive(1'b1, 16'h0100, 16'h0020, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check("load same edge uses old regs", 2, 16'h0000, 1'b0);
        drive(1'b0, 16'h0000, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        check("loaded values visible next word", 2, 16'h00E0, 1'b0);

        // R7: back-to-back last words keep done high for two cycles
        drive(1'b0, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        check("first last word", 7, 16'h0100, 1'b1);
        drive(1'b0, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        check("second last word", 7, 16'h0120, 1'b1);
        drive(1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check("done drops", 7, 16'h0120, 1'b0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: result=%h done=%b expected completion", result, done);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule